// File: doc/BRIEF.md
# MII management frame engine

This block is the master side of a two-wire PHY management link. It runs a single register read or write against an external PHY. A host pulses `start_i` with the access type, a 5-bit PHY address, a 5-bit register address and, for writes, 16 bits of data. The engine then produces a divided management clock and serializes the whole frame onto the data line. It hands the line to the PHY at the right bit and captures the returned word. When the access completes it raises `done_o` for one cycle.

The bidirectional data line appears as three plain signals: an output value `md_o`, an output enable `md_oe_o` and the resolved line level `md_i`. These connect to a tri-state pad outside the block. A pull-up on the line is assumed, so a line that nobody drives reads as 1.

A frame has 64 bits, numbered 0 to 63 in the order sent:

| Bits | Field |
|---|---|
| 0..31 | preamble |
| 32..33 | start |
| 34..35 | opcode |
| 36..40 | PHY address |
| 41..45 | register address |
| 46..47 | turnaround |
| 48..63 | data |

After bit 63 comes an idle phase, with the line released, before the engine accepts the next access.

Top module: `mgmt_frame_engine`

## Requirements
- R1: Every frame starts with 32 driven 1 bits, followed by the driven pair 0, 1.
- R2: The opcode bits are driven as 1, 0 for a read (`rd_i`=1) and as 0, 1 for a write (`rd_i`=0).
- R3: The PHY address is driven next, then the register address, each 5 bits long and sent most significant bit first.
- R4: On a write, the turnaround is driven as 1, 0. The 16 data bits are then driven most significant bit first.
- R5: On a read, `md_oe_o` is low from bit 46 through bit 63. On the rising clock edges of bits 48 to 63, `md_i` is shifted into `rdata_o`, most significant bit first. `rdata_o` holds the full word when `done_o` is high.
- R6: `mdc_o` has a period of 2×`HALF_DIV` system clocks while busy and stays low while not busy. `md_o` and `md_oe_o` change only at a falling `mdc_o` edge, or when a start is accepted.
- R7: `busy_o` rises in the cycle after a start is accepted and stays high until `done_o`. `done_o` is a single-cycle pulse, and `busy_o` is low while it is high. A `start_i` that arrives while busy is ignored.
- R8: `ta_err_o` is valid with `done_o`. It is 1 only on a read whose second turnaround bit was sampled as 1, and 0 on every other access.
- R9: After bit 63, the line is released for at least one full `mdc_o` period, which includes one rising edge with `md_oe_o` low. `done_o` comes on the falling edge that ends that period, so each access spans exactly 65 rising edges.
- R10: During and after reset, `mdc_o`, `md_oe_o`, `busy_o`, `done_o` and `ta_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start-of-access request pulse |
| rd_i | input | 1 | 1 selects a read, 0 a write |
| phy_addr_i | input | 5 | PHY address |
| reg_addr_i | input | 5 | Register address inside the PHY |
| wdata_i | input | 16 | Write data |
| mdc_o | output | 1 | Management clock |
| md_o | output | 1 | Data line value driven by the engine |
| md_oe_o | output | 1 | Data line drive enable |
| md_i | input | 1 | Resolved data line level |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | Access complete pulse |
| rdata_o | output | 16 | Captured read data |
| ta_err_o | output | 1 | Turnaround error on a read |

## Verification
A PHY model in the bench sees only the pins. On every rising clock edge it compares the driven bit and the enable against a frame that it builds on its own.

The bench runs these accesses:
- Writes with an all-ones data word and with an alternating data word. These separate the write turnaround from the data field.
- A read at an extreme address whose returned word has single set bits at both ends. This catches capture-order and off-by-one shift errors.
- A read whose PHY answers the second turnaround bit with 1. This must raise the error flag, and the read that follows must clear it again.
- A stray start pulse in the middle of a frame. This shows whether the engine restarts or queues a second access.

// File: rtl/mfe_pkg.sv
package mfe_pkg;

  localparam int FRAME_BITS = 64;
  localparam int TA_FIRST   = 46;
  localparam int TA_LAST    = 47;
  localparam int DATA_FIRST = 48;
  localparam int IDX_W      = $clog2(FRAME_BITS);

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FRAME = 2'd1,
    PH_REST  = 2'd2
  } phase_t;

  // Value placed on the line for frame bit position idx.
  function automatic logic frame_bit(input logic [IDX_W-1:0] idx,
                                     input logic             rd,
                                     input logic [4:0]       pa,
                                     input logic [4:0]       ra,
                                     input logic [15:0]      wd);
    int unsigned i;
    logic [2:0]  k;
    logic [3:0]  d;
    i = int'(idx);
    k = 3'd0;
    d = 4'd0;
    if (i < 32)        return 1'b1;
    else if (i == 32)  return 1'b0;
    else if (i == 33)  return 1'b1;
    else if (i == 34)  return rd;
    else if (i == 35)  return ~rd;
    else if (i <= 40) begin
      k = 3'(40 - i);
      return pa[k];
    end else if (i <= 45) begin
      k = 3'(45 - i);
      return ra[k];
    end else if (i == TA_FIRST) return 1'b1;
    else if (i == TA_LAST)      return 1'b0;
    else begin
      d = 4'(63 - i);
      return wd[d];
    end
  endfunction

  // Whether the master owns the line at bit position idx.
  function automatic logic drive_en(input logic [IDX_W-1:0] idx,
                                    input logic             rd);
    return !(rd && (int'(idx) >= TA_FIRST));
  endfunction

endpackage

// File: rtl/mfe_clkdiv.sv
module mfe_clkdiv #(
  parameter int HALF_DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick   = run_i && (cnt == CW'(HALF_DIV - 1));
  assign rise_o = tick && !mdc_o;
  assign fall_o = tick &&  mdc_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      mdc_o <= 1'b0;
    end else if (!run_i) begin
      cnt   <= '0;
      mdc_o <= 1'b0;
    end else if (tick) begin
      cnt   <= '0;
      mdc_o <= ~mdc_o;
    end else begin
      cnt   <= cnt + 1'b1;
    end
  end

  // R6: a rise strobe makes the clock high on the next cycle
  p_rise_sets_mdc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |=> mdc_o);

endmodule

// File: rtl/mfe_seq.sv
module mfe_seq
  import mfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             rd_i,
  input  logic [4:0]       phy_addr_i,
  input  logic [4:0]       reg_addr_i,
  input  logic [15:0]      wdata_i,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             md_o,
  output logic             md_oe_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             rd_q_o,
  output logic             in_frame_o,
  output logic             start_acc_o
);
  phase_t      phase;
  logic [4:0]  pa_q, ra_q;
  logic [15:0] wd_q;
  logic        rest_rise;
  logic        last_bit;

  assign busy_o      = (phase != PH_IDLE);
  assign in_frame_o  = (phase == PH_FRAME);
  assign start_acc_o = start_i && (phase == PH_IDLE);
  assign last_bit    = (idx_o == IDX_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      idx_o     <= '0;
      rd_q_o    <= 1'b0;
      pa_q      <= '0;
      ra_q      <= '0;
      wd_q      <= '0;
      md_o      <= 1'b1;
      md_oe_o   <= 1'b0;
      rest_rise <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (phase)
        PH_IDLE: if (start_acc_o) begin
          phase   <= PH_FRAME;
          idx_o   <= '0;
          rd_q_o  <= rd_i;
          pa_q    <= phy_addr_i;
          ra_q    <= reg_addr_i;
          wd_q    <= wdata_i;
          md_o    <= frame_bit('0, rd_i, phy_addr_i, reg_addr_i, wdata_i);
          md_oe_o <= 1'b1;
        end
        PH_FRAME: if (fall_i) begin
          if (last_bit) begin
            phase     <= PH_REST;
            md_oe_o   <= 1'b0;
            md_o      <= 1'b1;
            rest_rise <= 1'b0;
          end else begin
            idx_o   <= idx_o + 1'b1;
            md_o    <= frame_bit(idx_o + 1'b1, rd_q_o, pa_q, ra_q, wd_q);
            md_oe_o <= drive_en(idx_o + 1'b1, rd_q_o);
          end
        end
        PH_REST: begin
          if (rise_i) rest_rise <= 1'b1;
          if (fall_i && rest_rise) begin
            phase  <= PH_IDLE;
            done_o <= 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R6: line value and enable move only on a falling clock or a new access
  p_md_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_i && !start_acc_o) |=> ($stable(md_o) && $stable(md_oe_o)));

  // R9: the idle phase never drives the line
  p_rest_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_REST) |-> !md_oe_o);

endmodule

// File: rtl/mfe_rdcap.sv
module mfe_rdcap
  import mfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             rise_i,
  input  logic             in_frame_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             md_i,
  input  logic             md_oe_i,
  output logic [15:0]      rdata_o,
  output logic             ta_err_o
);
  logic sample_ta, sample_data;

  assign sample_ta   = rise_i && in_frame_i && rd_i && (idx_i == IDX_W'(TA_LAST));
  assign sample_data = rise_i && in_frame_i && rd_i && (int'(idx_i) >= DATA_FIRST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_o  <= '0;
      ta_err_o <= 1'b0;
    end else if (clr_i) begin
      rdata_o  <= '0;
      ta_err_o <= 1'b0;
    end else begin
      if (sample_ta)   ta_err_o <= md_i;
      if (sample_data) rdata_o  <= {rdata_o[14:0], md_i};
    end
  end

  // R5: the PHY's bits are only sampled while the master has let go
  p_sample_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_ta || sample_data) |-> !md_oe_i);

endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mfe_pkg::*;
#(
  parameter int HALF_DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start_i,
  input  logic        rd_i,
  input  logic [4:0]  phy_addr_i,
  input  logic [4:0]  reg_addr_i,
  input  logic [15:0] wdata_i,
  output logic        mdc_o,
  output logic        md_o,
  output logic        md_oe_o,
  input  logic        md_i,
  output logic        busy_o,
  output logic        done_o,
  output logic [15:0] rdata_o,
  output logic        ta_err_o
);
  logic             ev_rise, ev_fall;
  logic [IDX_W-1:0] bit_idx;
  logic             rd_q, in_frame, start_acc;

  mfe_clkdiv #(.HALF_DIV(HALF_DIV)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (busy_o),
    .mdc_o  (mdc_o),
    .rise_o (ev_rise),
    .fall_o (ev_fall)
  );

  mfe_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .rd_i        (rd_i),
    .phy_addr_i  (phy_addr_i),
    .reg_addr_i  (reg_addr_i),
    .wdata_i     (wdata_i),
    .rise_i      (ev_rise),
    .fall_i      (ev_fall),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .md_o        (md_o),
    .md_oe_o     (md_oe_o),
    .idx_o       (bit_idx),
    .rd_q_o      (rd_q),
    .in_frame_o  (in_frame),
    .start_acc_o (start_acc)
  );

  mfe_rdcap u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (start_acc),
    .rise_i     (ev_rise),
    .in_frame_i (in_frame),
    .rd_i       (rd_q),
    .idx_i      (bit_idx),
    .md_i       (md_i),
    .md_oe_i    (md_oe_o),
    .rdata_o    (rdata_o),
    .ta_err_o   (ta_err_o)
  );

  // R6: clock parked low outside an access
  p_mdc_parked_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !mdc_o);

  // R7: done lasts one cycle and is not overlapped by busy
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_done_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  p_start_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o);

  // R8: writes never report a turnaround error
  p_err_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !rd_q) |-> !ta_err_o);

endmodule

// File: tb/sim_mgmt_frame_engine.sv
module sim_mgmt_frame_engine;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start_i, rd_i;
  logic [4:0]  phy_addr_i, reg_addr_i;
  logic [15:0] wdata_i;
  logic        mdc_o, md_o, md_oe_o, md_i, busy_o, done_o, ta_err_o;
  logic [15:0] rdata_o;

  logic phy_drv = 1'b0;
  logic phy_val = 1'b1;
  assign md_i = md_oe_o ? md_o : (phy_drv ? phy_val : 1'b1);

  mgmt_frame_engine #(.HALF_DIV(HALF)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .rd_i(rd_i),
    .phy_addr_i(phy_addr_i), .reg_addr_i(reg_addr_i), .wdata_i(wdata_i),
    .mdc_o(mdc_o), .md_o(md_o), .md_oe_o(md_oe_o), .md_i(md_i),
    .busy_o(busy_o), .done_o(done_o), .rdata_o(rdata_o), .ta_err_o(ta_err_o)
  );

  typedef struct {
    bit        rd;
    bit [4:0]  pa;
    bit [4:0]  ra;
    bit [15:0] wd;
    bit [15:0] prd;
    bit        ta2;
  } item_t;

  item_t q[$];
  item_t cur;
  int checks = 0, fails = 0, dones = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int b, input bit rd);
    if (b < 34) return "R1";
    if (b < 36) return "R2";
    if (b < 46) return "R3";
    return rd ? "R5" : "R4";
  endfunction

  // Monitor / PHY model
  bit [63:0] exp_bits, exp_oe;
  bit mdc_q = 0, busy_q = 0, have_cur = 0;
  int rc = 0, fc = 0;
  longint cyc = 0, last_rise = 0;

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (busy_o && !busy_q) begin
        chk(q.size() > 0, "R7", "unexpected access started", q.size(), 1);
        if (q.size() > 0) begin
          cur = q.pop_front();
          have_cur = 1;
          exp_bits = {32'hFFFF_FFFF, 2'b01, (cur.rd ? 2'b10 : 2'b01), cur.pa, cur.ra,
                      (cur.rd ? 2'b11 : 2'b10), (cur.rd ? cur.prd : cur.wd)};
          exp_oe = cur.rd ? {{46{1'b1}}, {18{1'b0}}} : {64{1'b1}};
          rc = 0; fc = 0; phy_drv = 0;
        end
      end
      if (mdc_o && !mdc_q && have_cur) begin
        if (rc < 64) begin
          if (md_oe_o !== exp_oe[63-rc] || (exp_oe[63-rc] && md_o !== exp_bits[63-rc]))
            chk(0, req_of(rc, cur.rd), $sformatf("bit %0d oe/val", rc),
                {md_oe_o, md_o}, {exp_oe[63-rc], exp_bits[63-rc]});
          else if (rc == 0 || rc == 33 || rc == 35 || rc == 45 || rc == 47 || rc == 63)
            chk(1, req_of(rc, cur.rd), "bit", 0, 0);
        end else if (rc == 64) begin
          chk(!md_oe_o, "R9", "line released in idle phase", md_oe_o, 0);
        end
        if (rc == 1)
          chk(cyc - last_rise == 2*HALF, "R6", "mdc period", cyc - last_rise, 2*HALF);
        last_rise = cyc;
        rc++;
      end
      if (!mdc_o && mdc_q && have_cur) begin
        fc++;
        if (cur.rd && fc >= 47 && fc <= 63) begin
          phy_drv = 1;
          phy_val = (fc == 47) ? cur.ta2 : cur.prd[63-fc];
        end else begin
          phy_drv = 0;
        end
      end
      if (done_o) begin
        dones++;
        chk(rc == 65, "R9", "rising edges per access", rc, 65);
        chk(!busy_o, "R7", "busy low at done", busy_o, 0);
        if (have_cur && cur.rd) begin
          chk(rdata_o == cur.prd, "R5", "read data", rdata_o, cur.prd);
          chk(ta_err_o == cur.ta2, "R8", "turnaround error", ta_err_o, cur.ta2);
        end else begin
          chk(ta_err_o == 0, "R8", "error on write", ta_err_o, 0);
        end
        have_cur = 0;
      end
    end
    mdc_q  = mdc_o;
    busy_q = busy_o;
  end

  // Driver
  task automatic access(input bit rd, input bit [4:0] pa, input bit [4:0] ra,
                        input bit [15:0] wd, input bit [15:0] prd, input bit ta2,
                        input bit stray);
    item_t it;
    int d0;
    it.rd = rd; it.pa = pa; it.ra = ra; it.wd = wd; it.prd = prd; it.ta2 = ta2;
    q.push_back(it);
    d0 = dones;
    @(posedge clk); #1;
    start_i = 1; rd_i = rd; phy_addr_i = pa; reg_addr_i = ra; wdata_i = wd;
    @(posedge clk); #1;
    start_i = 0;
    @(negedge clk);
    chk(busy_o, "R7", "busy after start", busy_o, 1);
    if (stray) begin
      repeat (300) @(posedge clk);
      #1; start_i = 1; rd_i = ~rd; phy_addr_i = ~pa; reg_addr_i = ~ra; wdata_i = ~wd;
      @(posedge clk); #1; start_i = 0;
    end
    while (dones == d0) @(posedge clk);
    @(negedge clk);
    chk(dones == d0 + 1, "R7", "one done per access", dones - d0, 1);
  endtask

  task automatic finish_run();
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; start_i = 0; rd_i = 0; phy_addr_i = 0; reg_addr_i = 0; wdata_i = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk({mdc_o, md_oe_o, busy_o, done_o, ta_err_o} == 5'b0, "R10", "outputs in reset",
        {mdc_o, md_oe_o, busy_o, done_o, ta_err_o}, 0);
    #1 rst_n = 1;
    repeat (3) @(negedge clk);
    chk({mdc_o, md_oe_o, busy_o, done_o, ta_err_o} == 5'b0, "R10", "outputs after reset",
        {mdc_o, md_oe_o, busy_o, done_o, ta_err_o}, 0);

    access(0, 5'h01, 5'h01, 16'hA5C3, 16'h0, 0, 0);
    access(1, 5'h1F, 5'h00, 16'h0, 16'h8001, 0, 0);
    access(1, 5'h12, 5'h0D, 16'h0, 16'h7FFE, 1, 0);
    access(1, 5'h0A, 5'h15, 16'h0, 16'h3C5A, 0, 0);
    access(0, 5'h00, 5'h1F, 16'hFFFF, 16'h0, 0, 1);
    access(0, 5'h15, 5'h0A, 16'h5555, 16'h0, 0, 0);

    repeat (40) @(negedge clk);
    chk(!mdc_o && !busy_o, "R6", "clock parked when idle", {mdc_o, busy_o}, 0);
    chk(q.size() == 0, "R7", "no pending expected items", q.size(), 0);
    finish_run();
  end
endmodule